// File: doc/BRIEF.md
# Synchronous Burst PSRAM Write Controller

This block sits on the host side of a synchronous pseudo-static RAM and turns one user request into a fixed-length burst write. A request carries a start word address, four data words and a two-bit byte-lane mask per word. It is accepted through a valid/ready handshake. The controller then pulses the address-latch strobe with chip select low. It waits out a fixed write latency counted from the latch edge, drives the data beats in order, and finally closes the burst by raising chip select.

The memory can hold a beat back by pulling its wait line low at the capturing edge. The controller then presents the same beat again. Stalls stretch the burst, so a counter bounds the number of cycles chip select may stay low. With the default clock, the limit corresponds to 2.5 µs. When the limit is reached before the last beat is taken, the burst is closed. After the minimum high time, the remaining beats are re-issued as a new burst that starts at the next unwritten word. Output-enable and the mode-register select line are held inactive for the whole time.

Top module: `psram_bwr_ctrl`

## Requirements
- R1: After reset, and whenever no burst is in progress, chip select, latch strobe, write enable and both byte enables are high, the data bus enable is low and `req_ready` is high.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. In the following cycle, chip select goes low, the latch strobe is low for exactly that one cycle, and `mem_addr` carries the start address. `req_ready` stays low while chip select is low.
- R3: The first data beat is driven in the cycle ending at the LAT-th edge after the latch edge, which is the 5th edge by default. Beats follow in order 0..3 to consecutive word addresses. Beat b of a request is `req_data[b*DW +: DW]`.
- R4: If `mem_wait_n` is low at an edge during the data phase, that beat was not taken. The same beat, with the same data and lanes, is driven again in the next cycle.
- R5: Beat b uses the mask `req_mask[2*b +: 2]`. Bit 1 high drives the upper byte enable high and bit 0 high drives the lower byte enable high, so that lane is not written. With both bits high, the word is left unchanged.
- R6: Write enable is low whenever chip select is low. Output-enable and the mode-register select line stay high at all times.
- R7: Chip select is never low for more than MAX_OPEN consecutive cycles. If the limit is reached before the last beat is taken, the burst ends. The untaken beats are then sent as a new burst whose start address is the base address plus the number of beats already taken.
- R8: Between two bursts, chip select stays high for at least GAP cycles. `req_ready` rises only after that gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW | Start word address |
| req_data | input | BEATS*DW | Beat data, beat b at [b*DW +: DW] |
| req_mask | input | BEATS*2 | Lane masks, beat b at [2*b +: 2], bit 1 upper |
| mem_cs_n | output | 1 | Chip select, low active |
| mem_adv_n | output | 1 | Address latch strobe, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_oe_n | output | 1 | Output enable, held high |
| mem_regsel_n | output | 1 | Mode-register select, held high |
| mem_ub_n | output | 1 | Upper byte enable, low active |
| mem_lb_n | output | 1 | Lower byte enable, low active |
| mem_addr | output | AW | Word address |
| mem_dq_out | output | DW | Write data |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_wait_n | input | 1 | Low when the memory did not take the beat |

## Verification
Two things can happen in the same data cycle: the open-time limit can expire while the memory is stalling a beat, or it can expire just as a beat is accepted. The bench provokes both by keeping the limit small (12 cycles) and stalling the first beat for ten edges, so the cap expires mid-stall and the re-issued burst ends on exactly its last allowed cycle. The outcome is judged at the memory side. A bench-side memory model must end with exactly the expected words and lanes. The number of chip-select bursts must match the arithmetic prediction, and no low run may exceed the limit.

// File: rtl/psram_bwr_pkg.sv
// Package: shared state encoding of the burst write controller.
package psram_bwr_pkg;

    // Sequencer phases: idle, latch cycle, latency wait, data beats, inter-burst gap
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_LAT  = 3'd2,
        ST_DATA = 3'd3,
        ST_GAP  = 3'd4
    } bwr_state_e;

endpackage

// File: rtl/bwr_span_guard.sv
// Open-time guard.
// Counts consecutive cycles in which the burst is open. It flags the cycle
// that is the MAX_OPEN-th one, so the sequencer can close the burst at its end.
// Assumes: open is low for at least one cycle between bursts.
module bwr_span_guard #(
    parameter int MAX_OPEN = 312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    output logic cap_hit
);
    localparam int OCW = $clog2(MAX_OPEN + 1);

    logic [OCW-1:0] run_q;

    // count open cycles already completed, cleared while closed
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!open)
            run_q <= '0;
        else if (run_q != OCW'(MAX_OPEN))
            run_q <= run_q + 1'b1;
    end

    // the current cycle is the last one allowed
    always_comb cap_hit = open && (run_q == OCW'(MAX_OPEN - 1));

endmodule

// File: rtl/bwr_beat_store.sv
// Beat store.
// Captures all data words and lane masks of a request on load, and presents
// the beat picked by sel. Assumes: sel < BEATS.
module bwr_beat_store #(
    parameter int DW    = 16,
    parameter int BEATS = 4,
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [BEATS*DW-1:0]   in_data,
    input  logic [BEATS*2-1:0]    in_mask,
    input  logic [BW-1:0]         sel,
    output logic [DW-1:0]         beat_data,
    output logic [1:0]            beat_mask
);
    logic [DW-1:0] data_q [BEATS];
    logic [1:0]    mask_q [BEATS];

    for (genvar b = 0; b < BEATS; b++) begin : g_slot
        // hold one beat's word and lanes from request acceptance onward
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[b] <= '0;
                mask_q[b] <= 2'b11;
            end else if (load) begin
                data_q[b] <= in_data[b*DW +: DW];
                mask_q[b] <= in_mask[2*b +: 2];
            end
        end
    end

    // present the selected beat
    always_comb begin
        beat_data = data_q[sel];
        beat_mask = mask_q[sel];
    end

endmodule

// File: rtl/bwr_seq.sv
// Burst sequencer.
// Steps through latch, latency, data and gap phases. It advances a beat only
// when the memory reports it taken. On the open-time cap it closes the burst
// and re-issues the rest after the gap.
// Assumes: LAT >= 2, GAP >= 1, MAX_OPEN >= LAT + 1.
module bwr_seq
    import psram_bwr_pkg::*;
#(
    parameter int AW    = 20,
    parameter int BEATS = 4,
    parameter int LAT   = 5,
    parameter int GAP   = 2,
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int LCW  = $clog2(LAT + 1),
    localparam int GCW  = $clog2(GAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          beat_taken,
    input  logic          cap_hit,
    output bwr_state_e    state,
    output logic [BW-1:0] beat,
    output logic [AW-1:0] cur_addr
);
    logic [AW-1:0]  base_q;
    logic [LCW-1:0] lat_q;
    logic [GCW-1:0] gap_q;
    logic           resume_q;
    logic           last_beat;

    // the beat on the bus is the final one of the request
    always_comb last_beat = (beat == BW'(BEATS - 1));

    // phase sequencing and beat bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base_q   <= '0;
            beat     <= '0;
            lat_q    <= '0;
            gap_q    <= '0;
            resume_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_ADDR;
                    base_q   <= start_addr;
                    beat     <= '0;
                    resume_q <= 1'b0;
                end
                ST_ADDR: begin
                    lat_q <= '0;
                    state <= ST_LAT;
                end
                ST_LAT: begin
                    if (lat_q == LCW'(LAT - 2))
                        state <= ST_DATA;
                    else
                        lat_q <= lat_q + 1'b1;
                end
                ST_DATA: begin
                    gap_q <= '0;
                    if (beat_taken && last_beat) begin
                        state    <= ST_GAP;
                        resume_q <= 1'b0;
                    end else begin
                        if (beat_taken)
                            beat <= beat + 1'b1;
                        if (cap_hit) begin
                            state    <= ST_GAP;
                            resume_q <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_q == GCW'(GAP - 1))
                        state <= resume_q ? ST_ADDR : ST_IDLE;
                    else
                        gap_q <= gap_q + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // word address of the beat in flight, also the latch address
    always_comb cur_addr = base_q + AW'(beat);

endmodule

// File: rtl/psram_bwr_ctrl.sv
// Top: burst write controller for a synchronous pseudo-static RAM.
// Accepts one request of BEATS words and issues it as one burst, or as
// several if the open-time cap cuts it. Memory-side outputs are decoded from
// registered state only.
// Assumes: the memory is configured for LAT-cycle write latency and
// fixed-length bursts of at least BEATS words.
module psram_bwr_ctrl
    import psram_bwr_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int BEATS    = 4,
    parameter int LAT      = 5,
    parameter int MAX_OPEN = 312,
    parameter int GAP      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_addr,
    input  logic [BEATS*DW-1:0]   req_data,
    input  logic [BEATS*2-1:0]    req_mask,
    output logic                  mem_cs_n,
    output logic                  mem_adv_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic                  mem_regsel_n,
    output logic                  mem_ub_n,
    output logic                  mem_lb_n,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic                  mem_wait_n
);
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    bwr_state_e    state;
    logic [BW-1:0] beat;
    logic [1:0]    beat_mask;
    logic          start;
    logic          in_burst;
    logic          in_data;
    logic          cap_hit;

    // handshake and phase decode
    always_comb begin
        req_ready = (state == ST_IDLE);
        start     = req_valid && req_ready;
        in_burst  = (state == ST_ADDR) || (state == ST_LAT) || (state == ST_DATA);
        in_data   = (state == ST_DATA);
    end

    bwr_span_guard #(.MAX_OPEN(MAX_OPEN)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .open    (in_burst),
        .cap_hit (cap_hit)
    );

    bwr_seq #(.AW(AW), .BEATS(BEATS), .LAT(LAT), .GAP(GAP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (req_addr),
        .beat_taken (mem_wait_n),
        .cap_hit    (cap_hit),
        .state      (state),
        .beat       (beat),
        .cur_addr   (mem_addr)
    );

    bwr_beat_store #(.DW(DW), .BEATS(BEATS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .in_data   (req_data),
        .in_mask   (req_mask),
        .sel       (beat),
        .beat_data (mem_dq_out),
        .beat_mask (beat_mask)
    );

    // memory control pins from the current phase
    always_comb begin
        mem_cs_n     = !in_burst;
        mem_we_n     = !in_burst;
        mem_adv_n    = (state != ST_ADDR);
        mem_oe_n     = 1'b1;
        mem_regsel_n = 1'b1;
        mem_dq_oe    = in_data;
        mem_ub_n     = in_data ? beat_mask[1] : 1'b1;
        mem_lb_n     = in_data ? beat_mask[0] : 1'b1;
    end

endmodule

// File: rtl/psram_bwr_chk.sv
// Checker for psram_bwr_ctrl, bound below. It observes only the top-level
// ports and keeps its own run-length counters.
module psram_bwr_chk #(
    parameter int MAX_OPEN = 312,
    parameter int GAP      = 2,
    parameter int DW       = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_cs_n,
    input logic          mem_adv_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_wait_n
);
    logic [15:0] lo_run;
    logic [15:0] hi_run;

    // lengths of the current low and high runs of chip select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= 16'(GAP);
        end else begin
            lo_run <= mem_cs_n ? '0 : lo_run + 16'd1;
            hi_run <= !mem_cs_n ? '0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
        end
    end

    // R2
    adv_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !mem_cs_n);
    // R2
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n);
    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);
    // R6
    write_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !mem_we_n);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && mem_dq_oe && !mem_wait_n) |=> (mem_cs_n || $stable(mem_dq_out)));
    // R7
    open_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (lo_run < 16'(MAX_OPEN)));
    // R8
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (hi_run >= 16'(GAP)));

endmodule

bind psram_bwr_ctrl psram_bwr_chk #(.MAX_OPEN(MAX_OPEN), .GAP(GAP), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_adv_n  (mem_adv_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_out (mem_dq_out),
    .mem_wait_n (mem_wait_n)
);

// File: tb/psram_bwr_ctrl_bench.sv
// Bench: a memory model plus a sweep over all 256 mask combinations and four stall depths.
module psram_bwr_ctrl_bench;
    localparam int AW = 6, DW = 16, BEATS = 4, LAT = 5, MAX_OPEN = 12, GAP = 2;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [BEATS*DW-1:0] req_data = '0;
    logic [BEATS*2-1:0] req_mask = '0;
    logic mem_cs_n, mem_adv_n, mem_we_n, mem_oe_n, mem_regsel_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic mem_wait_n = 1'b1;

    always #4 clk = ~clk;

    psram_bwr_ctrl #(.AW(AW), .DW(DW), .BEATS(BEATS), .LAT(LAT), .MAX_OPEN(MAX_OPEN), .GAP(GAP))
    u_psram_bwr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_regsel_n(mem_regsel_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_wait_n(mem_wait_n)
    );

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    bit active = 0, seen_burst = 0;
    int edge_k = 0, ptr = 0, stall_left = 0, lo_run = 0, hi_run = 1000;
    int adv_cnt = 0, bursts = 0, first_acc = -1;
    int bad_r2 = 0, bad_r3 = 0, bad_r6 = 0, bad_r7 = 0, bad_r8 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_word(input int m, input int b);
        return DW'((m * 37 + b * 4369 + 2640) & 16'hFFFF);
    endfunction

    // memory model: each negedge stands for the edge that follows it
    always @(negedge clk) if (rst_n) begin
        if (mem_oe_n !== 1'b1 || mem_regsel_n !== 1'b1) bad_r6++;
        if (!mem_adv_n && mem_cs_n) bad_r2++;
        if (!mem_cs_n && mem_we_n) bad_r6++;
        if (!mem_cs_n && req_ready) bad_r2++;
        if (mem_cs_n) begin
            if (lo_run > 0 && adv_cnt != 1) bad_r2++;
            active = 0; lo_run = 0; hi_run++; mem_wait_n = 1'b1;
        end else begin
            if (lo_run == 0) begin
                bursts++;
                if (seen_burst && hi_run < GAP) bad_r8++;
                seen_burst = 1; adv_cnt = 0;
            end
            lo_run++; hi_run = 0;
            if (lo_run > MAX_OPEN) bad_r7++;
            if (!mem_adv_n) adv_cnt++;
            if (!active) begin
                if (!mem_adv_n) begin
                    active = 1; ptr = int'(mem_addr); edge_k = 0; mem_wait_n = 1'b1;
                end
            end else begin
                edge_k++;
                if (edge_k >= LAT && stall_left > 0) begin
                    mem_wait_n = 1'b0; stall_left--;
                end else mem_wait_n = 1'b1;
                if (edge_k >= LAT && mem_wait_n && !mem_we_n) begin
                    if (!mem_dq_oe) bad_r3++;
                    if (first_acc < 0) first_acc = edge_k;
                    if (!mem_ub_n) mem[ptr][15:8] = mem_dq_out[15:8];
                    if (!mem_lb_n) mem[ptr][7:0]  = mem_dq_out[7:0];
                    ptr = (ptr + 1) % DEPTH;
                end
            end
        end
    end

    task automatic run_req(input int m);
        int stall, base, bad_words;
        logic [DW-1:0] d;
        logic [1:0] mk;
        case (m % 4)
            0: stall = 0;
            1: stall = 1;
            2: stall = 3;
            default: stall = 10;
        endcase
        base = (m * 5) % 60;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DW'(16'hC3A0 ^ (i * 257));
            exp_mem[i] = mem[i];
        end
        for (int b = 0; b < BEATS; b++) begin
            d  = beat_word(m, b);
            mk = 2'((m >> (2 * b)) & 3);
            req_data[b*DW +: DW] = d;
            req_mask[2*b +: 2]   = mk;
            if (!mk[1]) exp_mem[base + b][15:8] = d[15:8];
            if (!mk[0]) exp_mem[base + b][7:0]  = d[7:0];
        end
        req_addr = AW'(base);
        stall_left = stall; bursts = 0; first_acc = -1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        do @(negedge clk); while (!req_ready);
        bad_words = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad_words++;
        // R3 R5: words, order and lanes as written
        chk(bad_words == 0, "R3/R5 memory words wrong", bad_words, 0);
        // R7: split only when the stall outlasts the cap
        chk(bursts == ((stall > 3) ? 2 : 1), "R7 burst count", bursts, (stall > 3) ? 2 : 1);
        // R3 R4: first beat taken at LAT plus stalled edges
        if (stall <= 3) chk(first_acc == LAT + stall, "R3/R4 first beat edge", first_acc, LAT + stall);
    endtask

    bit finished = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(mem_cs_n && mem_adv_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
            "R1 idle outputs", {mem_cs_n, mem_adv_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready},
            7'b1111101);
        for (int m = 0; m < 256; m++) run_req(m);
        // R1: idle again after the sweep
        chk(mem_cs_n && req_ready && !mem_dq_oe, "R1 idle after bursts", {mem_cs_n, req_ready, mem_dq_oe}, 3'b110);
        chk(bad_r2 == 0, "R2 strobe/ready violations", bad_r2, 0);
        chk(bad_r3 == 0, "R3 beat taken without bus drive", bad_r3, 0);
        chk(bad_r6 == 0, "R6 control pin violations", bad_r6, 0);
        chk(bad_r7 == 0, "R7 open-time overruns", bad_r7, 0);
        chk(bad_r8 == 0, "R8 short gaps", bad_r8, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule